// File: doc/BRIEF.md
# Multiframe Search Supervisor

Once a receiver has regained basic frame alignment, it must also find the CRC multiframe boundary. This supervisor times that search. A single-cycle frame-recovered pulse starts a millisecond counter, which advances on a 1 ms tick. A multiframe-found indication that arrives early in the search raises a sticky success flag. If no indication arrives within the give-up window, the supervisor raises a sticky failure flag. It then switches the link to frame-only operation and pulls the transmitted remote-alarm bit low.

Each flag has a mask bit, and both masks come out of reset set to 1. The interrupt request is the OR of every flag whose mask is 0. Software clears both flags with a read strobe. A later frame-recovered pulse starts a fresh search and leaves frame-only mode. An indication that arrives after the success window but before the give-up point ends the search quietly.

Top module: `mf_search_sup`

## Requirements
- R1: After reset the success flag, failure flag, search and frame-only outputs are 0, the alarm output is 1, both mask bits are 1, and the interrupt request is 0.
- R2: A frame-recovered pulse starts a search with the tick count at zero, clears frame-only mode and takes priority over every other input in that cycle, including while a search is already running.
- R3: A found indication during a search, with fewer than 400 ticks counted, sets the success flag and ends the search on the next edge.
- R4: A found indication during a search, with 400 to 499 ticks counted, ends the search and sets neither flag.
- R5: When the 500th tick of a search arrives without a found indication, the failure flag is set and the search ends. A found indication in that same cycle counts as a late find (R4) instead.
- R6: After a failure, frame-only mode is 1 and the transmitted alarm bit is 0 until the next frame-recovered pulse; the two are never active together with a search.
- R7: Both flags hold until a read strobe clears them, and a flag set in the same cycle as a read stays set.
- R8: The interrupt request is high when (success flag and not mask bit 0) or (failure flag and not mask bit 1). A mask write strobe loads both mask bits, and the mask output shows them.
- R9: Found indications and ticks received outside a search change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_rec_i | input | 1 | Frame alignment recovered pulse |
| mf_found_i | input | 1 | Multiframe alignment found |
| tick_1ms_i | input | 1 | One-millisecond tick |
| flag_rd_i | input | 1 | Status read strobe, clears flags |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_din_i | input | 2 | Mask data: bit 0 success, bit 1 failure |
| mask_o | output | 2 | Current mask bits |
| mf_ok_o | output | 1 | Sticky success flag |
| mf_fail_o | output | 1 | Sticky failure flag |
| search_o | output | 1 | Search in progress |
| frame_only_o | output | 1 | Frame-only fallback mode |
| tx_alarm_o | output | 1 | Transmitted remote-alarm bit |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong tick count becomes visible at the ports only at a window edge. There, the success flag goes up a cycle when it should not, or the failure flag arrives one tick early or late. For that reason the bench probes counts 399, 400 and 499 precisely. A stuck search or mode bit shows on search_o or frame_only_o on the very next edge, and the same holds for tx_alarm_o and irq_o. Comparing the outputs against the model on every clock therefore catches a fault within one cycle of the stimulus that exposes it.

// File: rtl/mf_search_sup.sv
module mf_search_sup #(
  parameter int OK_MS     = 400,
  parameter int GIVEUP_MS = 500,
  localparam int CNT_W    = $clog2(GIVEUP_MS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_rec_i,
  input  logic       mf_found_i,
  input  logic       tick_1ms_i,
  input  logic       flag_rd_i,
  input  logic       mask_wr_i,
  input  logic [1:0] mask_din_i,
  output logic [1:0] mask_o,
  output logic       mf_ok_o,
  output logic       mf_fail_o,
  output logic       search_o,
  output logic       frame_only_o,
  output logic       tx_alarm_o,
  output logic       irq_o
);

  logic [CNT_W-1:0] ms_cnt;
  logic             searching, fo, ok_f, fail_f;
  logic [1:0]       mask;

  wire active  = searching & ~frame_rec_i;
  wire found   = active & mf_found_i;
  wire early   = ms_cnt < CNT_W'(OK_MS);
  wire last_ms = ms_cnt == CNT_W'(GIVEUP_MS - 1);
  wire expire  = active & ~mf_found_i & tick_1ms_i & last_ms;
  wire set_ok  = found & early;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      searching <= 1'b0;
      ms_cnt    <= '0;
      fo        <= 1'b0;
    end else if (frame_rec_i) begin
      searching <= 1'b1;
      ms_cnt    <= '0;
      fo        <= 1'b0;
    end else if (searching) begin
      if (mf_found_i) begin
        searching <= 1'b0;
      end else if (tick_1ms_i) begin
        if (last_ms) begin
          searching <= 1'b0;
          fo        <= 1'b1;
        end else begin
          ms_cnt <= ms_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_f   <= 1'b0;
      fail_f <= 1'b0;
      mask   <= 2'b11;
    end else begin
      ok_f   <= set_ok | (ok_f & ~flag_rd_i);
      fail_f <= expire | (fail_f & ~flag_rd_i);
      if (mask_wr_i) mask <= mask_din_i;
    end
  end

  assign mask_o       = mask;
  assign mf_ok_o      = ok_f;
  assign mf_fail_o    = fail_f;
  assign search_o     = searching;
  assign frame_only_o = fo;
  assign tx_alarm_o   = ~fo;
  assign irq_o        = (ok_f & ~mask[0]) | (fail_f & ~mask[1]);

endmodule

// File: rtl/mf_search_sup_chk.sv
module mf_search_sup_chk #(
  parameter int GIVEUP_MS = 500,
  parameter int CNT_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_rec_i,
  input logic             flag_rd_i,
  input logic [1:0]       mask_o,
  input logic             mf_ok_o,
  input logic             mf_fail_o,
  input logic             search_o,
  input logic             frame_only_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] ms_cnt
);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rec_i |=> search_o && !frame_only_o);

  assert_ok_ends_search_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_ok_o) |-> $past(search_o) && !search_o);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ms_cnt < CNT_W'(GIVEUP_MS));

  assert_fail_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_fail_o) |-> frame_only_o && !search_o);

  assert_mode_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(search_o && frame_only_o));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_i && !search_o |=> !mf_ok_o && !mf_fail_o);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_o == 2'b11 |-> !irq_o);

endmodule

bind mf_search_sup mf_search_sup_chk #(.GIVEUP_MS(GIVEUP_MS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_rec_i(frame_rec_i), .flag_rd_i(flag_rd_i),
  .mask_o(mask_o), .mf_ok_o(mf_ok_o), .mf_fail_o(mf_fail_o), .search_o(search_o),
  .frame_only_o(frame_only_o), .irq_o(irq_o), .ms_cnt(ms_cnt)
);

// File: tb/mf_search_sup_tb.sv
module mf_search_sup_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm = 0, fnd = 0, tk = 0, rd = 0, mw = 0;
  logic [1:0] md = 2'b00;
  logic [1:0] mask_o;
  logic ok_o, fail_o, srch_o, fo_o, alm_o, irq_o;

  int total = 0, bad = 0;
  bit done = 0;
  int m_srch, m_cnt, m_ok, m_fail, m_fo, m_m0, m_m1;

  always #10 clk = ~clk;

  mf_search_sup dut_i (
    .clk(clk), .rst_n(rst_n), .frame_rec_i(frm), .mf_found_i(fnd), .tick_1ms_i(tk),
    .flag_rd_i(rd), .mask_wr_i(mw), .mask_din_i(md), .mask_o(mask_o),
    .mf_ok_o(ok_o), .mf_fail_o(fail_o), .search_o(srch_o), .frame_only_o(fo_o),
    .tx_alarm_o(alm_o), .irq_o(irq_o)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_srch = 0; m_cnt = 0; m_ok = 0; m_fail = 0; m_fo = 0; m_m0 = 1; m_m1 = 1;
  endtask

  task automatic model_step();
    int s_ok = 0, s_fail = 0;
    if (frm) begin
      m_srch = 1; m_cnt = 0; m_fo = 0;
    end else if (m_srch == 1) begin
      if (fnd) begin
        if (m_cnt < 400) s_ok = 1;
        m_srch = 0;
      end else if (tk) begin
        if (m_cnt == 499) begin s_fail = 1; m_fo = 1; m_srch = 0; end
        else m_cnt++;
      end
    end
    m_ok   = (s_ok   || (m_ok   && !rd)) ? 1 : 0;
    m_fail = (s_fail || (m_fail && !rd)) ? 1 : 0;
    if (mw) begin m_m0 = md[0]; m_m1 = md[1]; end
  endtask

  task automatic compare_all();
    check("R3 success flag", ok_o, m_ok);
    check("R5 failure flag", fail_o, m_fail);
    check("R2 search", srch_o, m_srch);
    check("R6 frame-only", fo_o, m_fo);
    check("R6 alarm bit", alm_o, m_fo ? 0 : 1);
    check("R8 mask", mask_o, m_m1 * 2 + m_m0);
    check("R8 irq", irq_o, ((m_ok && !m_m0) || (m_fail && !m_m1)) ? 1 : 0);
  endtask

  task automatic cyc(bit f, bit n, bit t, bit r, bit w, logic [1:0] d);
    frm = f; fnd = n; tk = t; rd = r; mw = w; md = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    frm = 0; fnd = 0; tk = 0; rd = 0; mw = 0; md = 2'b00;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0, 2'b00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    compare_all();
    check("R1 alarm after reset", alm_o, 1);
    check("R1 mask after reset", mask_o, 3);
    // R9 idle stimulus ignored
    cyc(0, 1, 1, 0, 0, 2'b00);
    ticks(5);
    check("R9 idle found ignored", ok_o, 0);
    // R3 early find
    cyc(1, 0, 0, 0, 0, 2'b00);
    ticks(10);
    cyc(0, 1, 0, 0, 0, 2'b00);
    check("R3 ok after early find", ok_o, 1);
    // R8 unmask success
    cyc(0, 0, 0, 0, 1, 2'b10);
    check("R8 irq unmasked", irq_o, 1);
    // R7 sticky then read clear
    ticks(3);
    check("R7 sticky", ok_o, 1);
    cyc(0, 0, 0, 1, 0, 2'b00);
    check("R7 read clears", ok_o, 0);
    // R3 boundary 399
    cyc(1, 0, 0, 0, 0, 2'b00);
    ticks(399);
    cyc(0, 1, 0, 0, 0, 2'b00);
    check("R3 find at 399", ok_o, 1);
    cyc(0, 0, 0, 1, 0, 2'b00);
    // R4 boundary 400 and 450
    cyc(1, 0, 0, 0, 0, 2'b00);
    ticks(400);
    cyc(0, 1, 0, 0, 0, 2'b00);
    check("R4 find at 400 no flag", ok_o + fail_o, 0);
    check("R4 search ended", srch_o, 0);
    cyc(1, 0, 0, 0, 0, 2'b00);
    ticks(450);
    cyc(0, 1, 1, 0, 0, 2'b00);
    check("R4 find at 450", ok_o + fail_o, 0);
    // R5/R6 timeout
    cyc(0, 0, 0, 0, 1, 2'b01);
    cyc(1, 0, 0, 0, 0, 2'b00);
    ticks(499);
    check("R5 not yet at 499", fail_o, 0);
    ticks(1);
    check("R5 fail at 500", fail_o, 1);
    check("R6 frame-only", fo_o, 1);
    check("R6 alarm low", alm_o, 0);
    check("R8 irq fail", irq_o, 1);
    cyc(0, 1, 1, 0, 0, 2'b00);
    check("R9 found after timeout ignored", ok_o, 0);
    // R7 set wins over read
    cyc(0, 0, 0, 1, 0, 2'b00);
    cyc(1, 0, 0, 0, 0, 2'b00);
    check("R2 leaves frame-only", fo_o, 0);
    ticks(5);
    cyc(0, 1, 0, 1, 0, 2'b00);
    check("R7 set beats read", ok_o, 1);
    cyc(0, 0, 0, 1, 0, 2'b00);
    // R5 found on 500th tick
    cyc(1, 0, 0, 0, 0, 2'b00);
    ticks(499);
    cyc(0, 1, 1, 0, 0, 2'b00);
    check("R5 found beats timeout", fail_o + fo_o + ok_o, 0);
    // R2 restart mid search, and frame beats found
    cyc(1, 0, 0, 0, 0, 2'b00);
    ticks(300);
    cyc(1, 1, 1, 0, 0, 2'b00);
    check("R2 frame priority", srch_o, 1);
    ticks(300);
    cyc(0, 1, 0, 0, 0, 2'b00);
    check("R2 restart counts from zero", ok_o, 1);
    finish_run();
  end
endmodule